// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash bus. Software or a command sequencer first issues a program or erase command. It then pulses `start`, and the poller reads the status byte over and over through a read-request / read-data handshake. Completion is found by comparing a watched status bit across two reads in a row. While the device's internal operation is running, that bit changes on every read. Once the operation is finished, the bit holds still.

When the watched bit is still changing, the poller looks at the device's timeout flag (bit 5 of the second read of a pair). If the flag is low, it starts another pair of reads. If the flag is high, it runs exactly one more confirmation pair, because the bit may have stopped changing at the same moment the flag went high.

The poller reports its result with a one-cycle `done` strobe, together with either `pass` or `fail`. A failure first raises a reset-command request, and the request stays up until the bus side acknowledges it. A watchdog can also force a failure after a set number of plain changing pairs. The status byte may be read at any address, so the poller drives no address.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: A `start` pulse seen while idle raises `rd_req` in the next cycle. The first completed read of a pair latches the watched bit: bit 6 with the default `WATCH_BIT`, or bit 2 when the parameter is set to 2.
- R2: If the watched bit in the second read of a pair equals the latched value, `done` and `pass` are high in the cycle after that read's `rd_valid`, and `rd_req` is low.
- R3: If the watched bit differs and bit 5 of the second read is low, the poller starts a new pair. Bit 5 of the first read of a pair has no effect.
- R4: If the watched bit differs and bit 5 of the second read is high, the poller runs exactly one confirmation pair.
- R5: A confirmation pair whose watched bit does not change ends in `done` with `pass`.
- R6: A confirmation pair whose watched bit changes raises `rst_cmd_req` in the cycle after its second read. The request is held until `rst_cmd_ack` is sampled high, and in the next cycle `done` and `fail` are high.
- R7: `done` lasts one cycle and comes with exactly one of `pass` and `fail`. Both are low whenever `done` is low.
- R8: With `MAX_PAIRS` greater than 0, the `MAX_PAIRS`-th pair that changes with bit 5 low ends in failure through the R6 reset-command path. A value of 0 disables this limit.
- R9: `start` has no effect while a poll or a reset-command request is in progress.
- R10: Holding `rst` high at a clock edge returns the poller to idle, with `rd_req`, `rst_cmd_req`, `done`, `pass` and `fail` low after that edge.
- R11: `rd_valid` is ignored while `rd_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (used only when idle) |
| rd_req | output | 1 | Status read wanted; held until `rd_valid` |
| rd_valid | input | 1 | Status byte on `rd_data` is valid this cycle |
| rd_data | input | DATA_W | Status byte returned by the bus |
| rst_cmd_req | output | 1 | Request to write the reset command; held until acknowledged |
| rst_cmd_ack | input | 1 | Bus has issued the reset command |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Operation completed (with `done`) |
| fail | output | 1 | Operation failed (with `done`) |

## Verification
A pass result is due exactly one cycle after the `rd_valid` of the deciding read. A reset-command request after a failed confirmation or a watchdog expiry is due at the same point. The fail strobe is due exactly one cycle after the acknowledge. The bench drives every input just after a falling edge and numbers every falling edge. It records the number of the last read handshake and of the acknowledge, then checks that the request and the strobe appear on precisely the following edge. Random read latency and acknowledge delay move these cycles around, so each deadline is measured from the recorded event and not from `start`.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_RST_CMD
    } poll_state_e;

    typedef enum logic [1:0] {
        VERD_MORE,
        VERD_CONFIRM,
        VERD_PASS,
        VERD_FAIL
    } verdict_e;

    // Observation of one completed read pair
    typedef struct packed {
        logic moved;   // watched bit differs from first read
        logic tout;    // timeout flag of the second read
    } pair_obs_t;

    // Decide what follows a completed pair
    function automatic verdict_e judge_pair(
        input pair_obs_t obs,
        input logic      confirming,
        input logic      wd_last
    );
        verdict_e v;
        if (!obs.moved)
            v = VERD_PASS;
        else if (confirming)
            v = VERD_FAIL;
        else if (obs.tout)
            v = VERD_CONFIRM;
        else if (wd_last)
            v = VERD_FAIL;
        else
            v = VERD_MORE;
        return v;
    endfunction

endpackage

// File: rtl/tgl_poll_cmp.sv
module tgl_poll_cmp
    import tgl_poll_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int WATCH_BIT = 6,
    parameter int TOUT_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_first,
    input  logic [DATA_W-1:0] rd_data,
    output pair_obs_t         obs
);

    logic first_q;

    always_ff @(posedge clk) begin
        if (rst)
            first_q <= 1'b0;
        else if (cap_first)
            first_q <= rd_data[WATCH_BIT];
    end

    assign obs.moved = rd_data[WATCH_BIT] ^ first_q;
    assign obs.tout  = rd_data[TOUT_BIT];

    // Remaining status bits carry no meaning for the poll
    logic unused_bits;
    assign unused_bits = ^rd_data;

endmodule

// File: rtl/tgl_poll_wdog.sv
module tgl_poll_wdog #(
    parameter int MAX_PAIRS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last_pair
);

    localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;

    generate
        if (MAX_PAIRS == 0) begin : g_off
            assign last_pair = 1'b0;
            logic unused_wd;
            assign unused_wd = clk ^ rst ^ clr ^ inc;
        end else begin : g_on
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clr)
                    cnt <= '0;
                else if (inc)
                    cnt <= cnt + 1'b1;
            end

            assign last_pair = (cnt == CW'(MAX_PAIRS - 1));

            // R8: the plain-pair count never reaches the limit
            a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
                ({1'b0, cnt} < (CW+1)'(MAX_PAIRS)));
        end
    endgenerate

endmodule

// File: rtl/tgl_poll_fsm.sv
module tgl_poll_fsm
    import tgl_poll_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      rd_valid,
    input  logic      rst_cmd_ack,
    input  pair_obs_t obs,
    input  logic      wd_last,
    output logic      rd_req,
    output logic      cap_first,
    output logic      wd_clr,
    output logic      wd_inc,
    output logic      rst_cmd_req,
    output logic      done,
    output logic      pass,
    output logic      fail
);

    poll_state_e state;
    logic        confirming;
    verdict_e    verdict;

    assign verdict     = judge_pair(obs, confirming, wd_last);
    assign rd_req      = (state == ST_RD_FIRST) || (state == ST_RD_SECOND);
    assign rst_cmd_req = (state == ST_RST_CMD);
    assign cap_first   = (state == ST_RD_FIRST) && rd_valid;
    assign wd_clr      = (state == ST_IDLE) && start;
    assign wd_inc      = (state == ST_RD_SECOND) && rd_valid && (verdict == VERD_MORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            confirming <= 1'b0;
            done       <= 1'b0;
            pass       <= 1'b0;
            fail       <= 1'b0;
        end else begin
            done <= 1'b0;
            pass <= 1'b0;
            fail <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_RD_FIRST;
                        confirming <= 1'b0;
                    end
                end
                ST_RD_FIRST: begin
                    if (rd_valid)
                        state <= ST_RD_SECOND;
                end
                ST_RD_SECOND: begin
                    if (rd_valid) begin
                        unique case (verdict)
                            VERD_PASS: begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                pass  <= 1'b1;
                            end
                            VERD_FAIL: state <= ST_RST_CMD;
                            VERD_CONFIRM: begin
                                confirming <= 1'b1;
                                state      <= ST_RD_FIRST;
                            end
                            default: state <= ST_RD_FIRST;
                        endcase
                    end
                end
                default: begin
                    if (rst_cmd_ack) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        fail  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R1: a start taken in idle leads to a read request
    a_r1_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!rd_req && !rst_cmd_req && start) |=> rd_req);

    // R2: a passing result stops further reads
    a_r2_no_read_after_pass: assert property (@(posedge clk) disable iff (rst)
        pass |-> !rd_req);

    // R6: the reset-command request holds until acknowledged
    a_r6_hold_cmd_req: assert property (@(posedge clk) disable iff (rst)
        (rst_cmd_req && !rst_cmd_ack) |=> rst_cmd_req);

    // R6: a failure only follows an acknowledged request
    a_r6_fail_after_ack: assert property (@(posedge clk) disable iff (rst)
        fail |-> $past(rst_cmd_req && rst_cmd_ack));

    // R7: one result flag with each strobe
    a_r7_done_exclusive: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass != fail));

    // R7: result flags only with the strobe
    a_r7_flags_with_done: assert property (@(posedge clk) disable iff (rst)
        (pass || fail) |-> done);

    // R7: strobe lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: reset leaves all requests and results low
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!rd_req && !rst_cmd_req && !done && !pass && !fail));

endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
    import tgl_poll_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int WATCH_BIT = 6,
    parameter int TOUT_BIT  = 5,
    parameter int MAX_PAIRS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rst_cmd_req,
    input  logic              rst_cmd_ack,
    output logic              done,
    output logic              pass,
    output logic              fail
);

    pair_obs_t obs;
    logic      cap_first;
    logic      wd_clr;
    logic      wd_inc;
    logic      wd_last;

    tgl_poll_cmp #(
        .DATA_W    (DATA_W),
        .WATCH_BIT (WATCH_BIT),
        .TOUT_BIT  (TOUT_BIT)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .cap_first (cap_first),
        .rd_data   (rd_data),
        .obs       (obs)
    );

    tgl_poll_wdog #(
        .MAX_PAIRS (MAX_PAIRS)
    ) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .clr       (wd_clr),
        .inc       (wd_inc),
        .last_pair (wd_last)
    );

    tgl_poll_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .rd_valid    (rd_valid),
        .rst_cmd_ack (rst_cmd_ack),
        .obs         (obs),
        .wd_last     (wd_last),
        .rd_req      (rd_req),
        .cap_first   (cap_first),
        .wd_clr      (wd_clr),
        .wd_inc      (wd_inc),
        .rst_cmd_req (rst_cmd_req),
        .done        (done),
        .pass        (pass),
        .fail        (fail)
    );

endmodule

// File: tb/tgl_poll_ctrl_test.sv
`timescale 1ns/1ps
module tgl_poll_ctrl_test;

    localparam int WB   = 6;
    localparam int MAXP = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_req;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       rst_cmd_req;
    logic       rst_cmd_ack = 1'b0;
    logic       done;
    logic       pass;
    logic       fail;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] seq [64];

    always #10 clk = ~clk;

    tgl_poll_ctrl #(.WATCH_BIT(WB), .MAX_PAIRS(MAXP)) uut (
        .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rst_cmd_req(rst_cmd_req),
        .rst_cmd_ack(rst_cmd_ack), .done(done), .pass(pass), .fail(fail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit w, input bit t);
        logic [7:0] b;
        b = 8'($urandom);
        b[WB] = w;
        b[5]  = t;
        return b;
    endfunction

    // Expected outcome from the requirements: pass flag and reads consumed
    function automatic void model(output bit ok, output int nreads);
        int  plain = 0;
        bit  conf = 0;
        bit  fin = 0;
        ok = 0;
        nreads = 0;
        for (int i = 0; i + 1 < 64 && !fin; i += 2) begin
            nreads = i + 2;
            if (seq[i][WB] == seq[i+1][WB]) begin
                ok = 1; fin = 1;
            end else if (conf) begin
                ok = 0; fin = 1;
            end else if (seq[i+1][5]) begin
                conf = 1;
            end else begin
                plain++;
                if (plain == MAXP) begin ok = 0; fin = 1; end
            end
        end
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 64; i++)
            seq[i] = mk(1'($urandom), ($urandom_range(5, 0) == 0));
    endtask

    task automatic run_trial(input string tag, input int lat_max, input bit spam);
        bit exp_ok;
        int exp_n;
        int idx = 0;
        int cyc = 0;
        int last_rd = -10;
        int req_cyc = -1;
        int ack_cyc = -1;
        int done_cyc = -1;
        int lat_cnt;
        int ack_wait;
        bit got_pass = 0;
        bit got_fail = 0;
        model(exp_ok, exp_n);
        @(negedge clk);
        start = 1'b1;
        lat_cnt = $urandom_range(lat_max, 0);
        ack_wait = $urandom_range(3, 0);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) check(rd_req == 1'b1, {tag, " R1 rd_req after start"}, rd_req, 1);
            start = spam ? 1'($urandom) : 1'b0;
            rd_valid = 1'b0;
            rst_cmd_ack = 1'b0;
            if (done) begin
                done_cyc = cyc; got_pass = pass; got_fail = fail;
                break;
            end
            if (rst_cmd_req && req_cyc < 0) req_cyc = cyc;
            if (rd_req) begin
                if (lat_cnt == 0) begin
                    rd_valid = 1'b1;
                    rd_data = seq[idx % 64];
                    idx++;
                    last_rd = cyc;
                    lat_cnt = $urandom_range(lat_max, 0);
                end else lat_cnt--;
            end else if (rst_cmd_req) begin
                if (ack_wait == 0) begin
                    rst_cmd_ack = 1'b1;
                    ack_cyc = cyc;
                end else ack_wait--;
            end
        end
        start = 1'b0;
        rd_valid = 1'b0;
        rst_cmd_ack = 1'b0;
        check(done_cyc > 0, {tag, " R7 done seen"}, done_cyc, 1);
        check(got_pass == exp_ok && got_fail == !exp_ok, {tag, " R7 outcome pass"}, got_pass, exp_ok);
        check(idx == exp_n, {tag, " R3 reads consumed"}, idx, exp_n);
        if (exp_ok) begin
            check(done_cyc == last_rd + 1, {tag, " R2 pass timing"}, done_cyc, last_rd + 1);
        end else begin
            check(req_cyc == last_rd + 1, {tag, " R6 request timing"}, req_cyc, last_rd + 1);
            check(done_cyc == ack_cyc + 1, {tag, " R6 fail after ack"}, done_cyc, ack_cyc + 1);
        end
        @(negedge clk);
        check(!done && !pass && !fail, {tag, " R7 single strobe"}, done, 0);
        check(!rd_req && !rst_cmd_req, {tag, " R9 idle after result"}, rd_req, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!rd_req && !rst_cmd_req && !done && !pass && !fail, "R10 reset state", rd_req, 0);

        // R11: rd_valid with garbage while idle
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd_valid = 1'b1;
            rd_data = 8'($urandom);
        end
        @(negedge clk);
        rd_valid = 1'b0;
        check(!rd_req && !done && !rst_cmd_req, "R11 stray rd_valid ignored", done, 0);

        void'($urandom(32'd1234));

        // R2 immediate settle
        fill_random(); seq[0] = mk(0, 0); seq[1] = mk(0, 1);
        run_trial("R2 immediate", 2, 0);
        // R3 toggling then settle
        fill_random(); seq[0] = mk(0, 0); seq[1] = mk(1, 0);
        seq[2] = mk(1, 0); seq[3] = mk(0, 0); seq[4] = mk(1, 1); seq[5] = mk(1, 0);
        run_trial("R3 toggle settle", 1, 0);
        // R3 bit 5 on first read only: no confirm, plain polling continues
        fill_random(); seq[0] = mk(0, 1); seq[1] = mk(1, 0);
        seq[2] = mk(0, 1); seq[3] = mk(1, 0); seq[4] = mk(0, 0); seq[5] = mk(0, 0);
        run_trial("R3 first-read bit5", 0, 0);
        // R4/R5 confirm pair settles
        fill_random(); seq[0] = mk(0, 0); seq[1] = mk(1, 1); seq[2] = mk(1, 1); seq[3] = mk(1, 1);
        run_trial("R5 confirm pass", 2, 0);
        // R4/R6 confirm pair still toggling
        fill_random(); seq[0] = mk(0, 0); seq[1] = mk(1, 1); seq[2] = mk(0, 0); seq[3] = mk(1, 0);
        run_trial("R6 confirm fail", 1, 0);
        // R8 watchdog
        fill_random();
        for (int i = 0; i < 64; i += 2) begin seq[i] = mk(0, 0); seq[i+1] = mk(1, 0); end
        run_trial("R8 watchdog", 0, 0);
        // R9 start pulses while busy
        fill_random(); seq[0] = mk(1, 0); seq[1] = mk(0, 0); seq[2] = mk(0, 0); seq[3] = mk(1, 1);
        seq[4] = mk(1, 0); seq[5] = mk(0, 0);
        run_trial("R9 start while busy", 3, 1);

        // R10 reset mid-poll
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(rd_req == 1'b1, "R1 poll running before reset", rd_req, 1);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!rd_req && !rst_cmd_req && !done, "R10 reset mid-poll", rd_req, 0);
        @(negedge clk);
        check(!rd_req, "R10 stays idle", rd_req, 0);

        // Random trials
        for (int t = 0; t < 60; t++) begin
            fill_random();
            run_trial("random", 3, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule